// File: doc/BRIEF.md
# Fully Associative Tag Store with Pointer-Based Victim Selection

This block holds the tags of a small fully associative structure and decides, on every miss, which entry gives way to the incoming tag. Each request tag is compared against every valid entry in the same cycle. The block reports a one-hot match vector, a hit flag and the encoded index of the matching entry, all combinationally from the stored state.

Victim choice needs no per-entry age history. A single replacement pointer names one candidate entry. The pointer steps forward by one whenever the entry it names is accessed, whether by a hit or by a fill. Accesses to any other entry leave it alone. As a result, the entry most recently touched is never the one the pointer names. While empty entries remain, a miss fills the lowest-numbered empty entry rather than the pointed one.

A client drives `reqValid` with `reqTag` and reads `hit`, `hitIdx` and `matchVec` in the same cycle. On a miss, `fillIdx` shows the entry that the next clock edge overwrites. The data array and any memory port lie outside this block.

Top module: `nmru_tag_store`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses, and `replPtr` is 0.
- R2: With `reqValid` high, the request tag is compared with all valid entries in the same cycle. `matchVec` has bit k set exactly when entry k holds the tag, `hit` is the OR of `matchVec`, and `hitIdx` is the binary index of the set bit. When nothing matches, `matchVec` and `hitIdx` are 0.
- R3: A hit on the entry `replPtr` names advances `replPtr` by one at the next clock edge.
- R4: A hit on any other entry leaves `replPtr` unchanged. A cycle with `reqValid` low changes neither `replPtr` nor the stored tags.
- R5: A miss when all entries are valid writes the request tag into the entry `replPtr` names. `replPtr` then advances by one, because the fill counts as an access to that entry.
- R6: A miss while some entry is invalid writes the tag into the lowest-numbered invalid entry and marks it valid. `replPtr` advances only if that entry is the one it names.
- R7: `replPtr` wraps from the last entry (63) back to 0.
- R8: During a miss cycle, `fillIdx` shows the entry that the fill will write.
- R9: After a fill, the evicted tag no longer hits, the new tag hits at the filled index, and the tags in all other entries still hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A lookup, plus a fill on a miss, is requested this cycle |
| reqTag | input | 20 | Tag to look up or insert |
| hit | output | 1 | Request tag found in a valid entry |
| hitIdx | output | 6 | Index of the matching entry (0 on a miss) |
| matchVec | output | 64 | One-hot per-entry match vector |
| fillIdx | output | 6 | Entry written if this request misses |
| replPtr | output | 6 | Current replacement pointer |

## Verification
The hardest state to reach from the ports is a full store with the pointer wrapped round. Only there does a miss evict a live entry, and only there does the choice between a pointed and an unpointed hit decide where the next eviction lands. The stimulus first builds a short history by hand. It then streams misses with distinct tags until every entry is filled and the pointer has wrapped to 0. Next it hits a non-pointed entry and then the pointed entry. Finally it misses twice, which evicts two known tags, and confirms that those tags are gone while their neighbours remain.

// File: rtl/nmru_pkg.sv
package nmru_pkg;
  localparam int NUM_ENTRIES = 64;
  localparam int TAG_W       = 20;
  localparam int IDX_W       = $clog2(NUM_ENTRIES);

  // strobes from the control to the datapath
  typedef struct packed {
    logic             fillEn;
    logic [IDX_W-1:0] fillIdx;
  } storeCtrl_t;
endpackage

// File: rtl/nmru_tag_dp.sv
module nmru_tag_dp
  import nmru_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [TAG_W-1:0] reqTag,
  input  storeCtrl_t       ctrl,
  output logic [NUM_ENTRIES-1:0] matchVec,
  output logic             hit,
  output logic [IDX_W-1:0] hitIdx,
  output logic             anyFree,
  output logic [IDX_W-1:0] firstFree
);
  logic [TAG_W-1:0]       tagMem [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] validVec;

  // valid bits carry reset, tags do not
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
    end else if (ctrl.fillEn) begin
      validVec[ctrl.fillIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.fillEn) begin
      tagMem[ctrl.fillIdx] <= reqTag;
    end
  end

  // parallel compare, one comparator per entry
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    assign matchVec[e] = validVec[e] && (tagMem[e] == reqTag);
  end

  assign hit = |matchVec;

  // one-hot to binary encode
  always_comb begin
    hitIdx = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (matchVec[e]) hitIdx = hitIdx | IDX_W'(e);
    end
  end

  // lowest-numbered invalid entry
  assign anyFree = ~&validVec;
  always_comb begin
    firstFree = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (!validVec[e]) firstFree = IDX_W'(e);
    end
  end
endmodule

// File: rtl/nmru_repl_ctrl.sv
module nmru_repl_ctrl
  import nmru_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             hit,
  input  logic [IDX_W-1:0] hitIdx,
  input  logic             anyFree,
  input  logic [IDX_W-1:0] firstFree,
  output storeCtrl_t       ctrl,
  output logic [IDX_W-1:0] fillTarget,
  output logic [IDX_W-1:0] replPtr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] touchIdx;
  logic             ptrTouched;
  logic [IDX_W-1:0] ptrNext;

  assign fillTarget   = anyFree ? firstFree : replPtr;
  assign ctrl.fillEn  = reqValid && !hit;
  assign ctrl.fillIdx = fillTarget;

  assign touchIdx   = hit ? hitIdx : fillTarget;
  assign ptrTouched = reqValid && (touchIdx == replPtr);
  assign ptrNext    = (replPtr == LAST_IDX) ? '0 : replPtr + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      replPtr <= '0;
    end else if (ptrTouched) begin
      replPtr <= ptrNext;
    end
  end
endmodule

// File: rtl/nmru_tag_store.sv
module nmru_tag_store
  import nmru_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [TAG_W-1:0]       reqTag,
  output logic                   hit,
  output logic [IDX_W-1:0]       hitIdx,
  output logic [NUM_ENTRIES-1:0] matchVec,
  output logic [IDX_W-1:0]       fillIdx,
  output logic [IDX_W-1:0]       replPtr
);
  storeCtrl_t       ctrl;
  logic             anyFree;
  logic [IDX_W-1:0] firstFree;

  nmru_tag_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqTag    (reqTag),
    .ctrl      (ctrl),
    .matchVec  (matchVec),
    .hit       (hit),
    .hitIdx    (hitIdx),
    .anyFree   (anyFree),
    .firstFree (firstFree)
  );

  nmru_repl_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .hit        (hit),
    .hitIdx     (hitIdx),
    .anyFree    (anyFree),
    .firstFree  (firstFree),
    .ctrl       (ctrl),
    .fillTarget (fillIdx),
    .replPtr    (replPtr)
  );
endmodule

// File: rtl/nmru_tag_store_chk.sv
module nmru_tag_store_chk
  import nmru_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic                   hit,
  input logic [IDX_W-1:0]       hitIdx,
  input logic [NUM_ENTRIES-1:0] matchVec,
  input logic [IDX_W-1:0]       fillIdx,
  input logic [IDX_W-1:0]       replPtr
);
  // R2: never two matching entries
  p_onehot_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  // R2: reported index points at a matching entry
  p_idx_matches_r2: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> matchVec[hitIdx]);

  // R3: hit on the pointed entry steps the pointer
  p_ptr_step_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && hit && hitIdx == replPtr) |=> replPtr == IDX_W'($past(replPtr) + 1'b1));

  // R4: hit elsewhere keeps the pointer
  p_ptr_keep_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && hit && hitIdx != replPtr) |=> $stable(replPtr));

  // R4: idle cycle keeps the pointer
  p_ptr_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(replPtr));

  // R6: fill away from the pointer keeps it
  p_ptr_keep_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !hit && fillIdx != replPtr) |=> $stable(replPtr));

  // R5: fill at the pointer steps it
  p_ptr_step_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !hit && fillIdx == replPtr) |=> replPtr == IDX_W'($past(replPtr) + 1'b1));
endmodule

bind nmru_tag_store nmru_tag_store_chk u_chk (.*);

// File: tb/tb_nmru_tag_store.sv
`timescale 1ns/1ps
module tb_nmru_tag_store;
  import nmru_pkg::*;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   reqValid = 1'b0;
  logic [TAG_W-1:0]       reqTag = '0;
  logic                   hit;
  logic [IDX_W-1:0]       hitIdx;
  logic [NUM_ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]       fillIdx;
  logic [IDX_W-1:0]       replPtr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // observations from the last step
  logic             oHit;
  logic [IDX_W-1:0] oIdx;
  logic [NUM_ENTRIES-1:0] oVec;
  logic [IDX_W-1:0] oFill;
  logic [IDX_W-1:0] oPtr;

  always #4 clk = ~clk;  // 125 MHz

  nmru_tag_store dut (.*);

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             expHit;
    logic [IDX_W-1:0] expIdx;   // hit index, or fill index on a miss
    logic [IDX_W-1:0] expPtr;   // pointer after the edge
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{20'h00100, 1'b0, 6'd0, 6'd1},  // R6 empty store, fill 0 = pointer
    '{20'h00100, 1'b1, 6'd0, 6'd1},  // R4 hit on 0, pointer at 1
    '{20'h00200, 1'b0, 6'd1, 6'd2},  // R6
    '{20'h00100, 1'b1, 6'd0, 6'd2},  // R4
    '{20'h00300, 1'b0, 6'd2, 6'd3},  // R6
    '{20'h00200, 1'b1, 6'd1, 6'd3}   // R4
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [TAG_W-1:0] tag);
    @(negedge clk);
    reqValid = 1'b1;
    reqTag   = tag;
    #2;
    oHit  = hit;
    oIdx  = hitIdx;
    oVec  = matchVec;
    oFill = fillIdx;
    @(posedge clk);
    #1;
    oPtr = replPtr;
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pointer at reset", replPtr, 0);
    @(negedge clk);
    rstN = 1'b1;

    // table walk
    foreach (VECS[i]) begin
      step(VECS[i].tag);
      chk("R2 hit flag", oHit, VECS[i].expHit);
      if (VECS[i].expHit) begin
        chk("R2 hit index", oIdx, VECS[i].expIdx);
        chk("R2 match vector", oVec, 64'd1 << VECS[i].expIdx);
      end else begin
        chk("R8 fill index", oFill, VECS[i].expIdx);
        chk("R2 match vector on miss", oVec, 0);
      end
      chk("R4 R6 pointer after", oPtr, VECS[i].expPtr);
    end

    // idle cycles leave pointer and contents alone
    idle();
    idle();
    idle();
    #1;
    chk("R4 pointer after idle", replPtr, 3);

    // fill every remaining entry
    for (int i = 3; i < NUM_ENTRIES; i++) begin
      step(TAG_W'(32'h1000 + i));
      chk("R6 fill lowest free", oFill, i);
      if (oHit) chk("R6 miss expected", oHit, 0);
    end
    chk("R7 pointer wraps to 0", oPtr, 0);

    // hit elsewhere, pointer stays
    step(20'h01028);
    chk("R2 hit index 40", oIdx, 40);
    chk("R4 pointer kept on other hit", oPtr, 0);

    // hit pointed entry
    step(20'h00100);
    chk("R3 hit entry 0", oIdx, 0);
    chk("R3 pointer advanced", oPtr, 1);

    // full store miss evicts entry 1 (0x200)
    step(20'hABCDE);
    chk("R5 miss", oHit, 0);
    chk("R5 victim is pointer", oFill, 1);
    chk("R5 pointer after fill", oPtr, 2);

    // evicted tag now misses, refilled at entry 2 (evicts 0x300)
    step(20'h00200);
    chk("R9 evicted tag misses", oHit, 0);
    chk("R9 R8 refill at pointer", oFill, 2);
    chk("R5 pointer after second fill", oPtr, 3);

    step(20'hABCDE);
    chk("R9 new tag hits", oHit, 1);
    chk("R9 new tag index", oIdx, 1);
    chk("R4 pointer kept", oPtr, 3);

    step(20'h00300);
    chk("R9 second evicted tag misses", oHit, 0);
    chk("R5 victim entry 3", oFill, 3);
    chk("R5 pointer to 4", oPtr, 4);

    step(20'h01010);
    chk("R9 neighbour survives", oHit, 1);
    chk("R9 neighbour index", oIdx, 16);
    chk("R4 pointer stays 4", oPtr, 4);

    step(20'h00100);
    chk("R9 entry 0 survives", oIdx, 0);
    chk("R9 entry 0 hit", oHit, 1);

    // reset in mid operation
    idle();
    rstN = 1'b0;
    #2;
    chk("R1 pointer cleared", replPtr, 0);
    @(negedge clk);
    rstN = 1'b1;
    step(20'h00100);
    chk("R1 store empty after reset", oHit, 0);
    chk("R1 fill at entry 0", oFill, 0);
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule